// File: doc/BRIEF.md
# Cartridge ROM-Window Register Overlay Decoder

This block sits on the cartridge side of an 8-bit CPU bus and turns the address, the read/write line and the data-phase clock into read enables. It first forms a ROM-window select, active when the upper address bit is set (addresses $8000 to $FFFF) and the CPU clock is in its data phase. A second stage then splits that select with the lower address bits. One address in the window is taken by a readable status register, and every other window address goes to the program ROM.

On a read, the block produces the byte to place on the CPU data bus together with an output enable. The register value has priority over ROM data at its own address. The pad-level tri-state buffer is built outside from `dataOut` and `dataOe`. The register address is a parameter, $8000 by default. It should be kept within $8000 to $BFFF so that the cartridge can reuse the window select it already receives. All outputs follow the inputs combinationally and add no register stage.

Top module: `rom_overlay_decoder`

## Requirements
- R1: `romSelect` is 1 exactly when `cpuPhi2` is 1 and `cpuAddr` is $8000 or higher, whatever the value of `cpuRw`.
- R2: `regEnable` is 1 exactly when `romSelect` is 1, `cpuRw` is 1 (read) and `cpuAddr` equals the `REG_ADDR` parameter.
- R3: `romEnable` is 1 exactly when `romSelect` is 1, `cpuRw` is 1 and `cpuAddr` differs from `REG_ADDR`.
- R4: `romEnable` and `regEnable` are never 1 at the same time.
- R5: `dataOe` is 1 exactly when `romSelect` is 1 and `cpuRw` is 1. During writes (`cpuRw` = 0) it is 0 for every address and phase.
- R6: `dataOut` equals `statusVal` while `regEnable` is 1 and equals `romData` while `romEnable` is 1. It is all zeros while `dataOe` is 0.
- R7: Every output reflects the present inputs with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuAddr | input | ADDR_W (16) | CPU address bus |
| cpuRw | input | 1 | 1 = read, 0 = write |
| cpuPhi2 | input | 1 | 1 while the clock is in its data-transfer phase |
| statusVal | input | DATA_W (8) | Present contents of the readable status register |
| romData | input | DATA_W (8) | Byte from the ROM read path |
| romSelect | output | 1 | First-level window select |
| romEnable | output | 1 | ROM read enable |
| regEnable | output | 1 | Status-register read enable |
| dataOut | output | DATA_W (8) | Byte to drive onto the CPU data bus |
| dataOe | output | 1 | Output enable for the data-bus buffer |

## Verification
The bench builds two instances side by side with the default 16-bit address and 8-bit data. One places the register at $8000, the default. The other places it at $BFFF, the top of the half of the window that may hold registers. Both instances take every address in both clock phases and for both read and write. Every boundary ($7FFF, $8000, $BFFF, $C000, $FFFF) is therefore covered, along with the register address at both edges of the permitted range. The register and ROM bytes are derived from the address, so a wrong source selection shows up as a wrong value.

// File: rtl/overlay_pkg.sv
package overlay_pkg;

  // Strobes passed from the decode control to the data path.
  typedef struct packed {
    logic romSel;  // ROM read in progress
    logic regSel;  // status register read in progress
    logic drive;   // data bus is to be driven
  } strobe_t;

endpackage

// File: rtl/overlay_ctrl.sv
module overlay_ctrl
  import overlay_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h8000
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRw,
  input  logic              cpuPhi2,
  output logic              romSelect,
  output strobe_t           strobes
);

  localparam int LOW_W = ADDR_W - 1;

  logic windowHit;
  logic lowMatch;
  logic readCycle;

  // First level: upper address bit and data phase give the window select.
  assign windowHit = cpuAddr[ADDR_W-1];
  assign romSelect = windowHit & cpuPhi2;

  // Second level: the lower lines pick the register out of the window.
  assign lowMatch  = (cpuAddr[LOW_W-1:0] == REG_ADDR[LOW_W-1:0]);
  assign readCycle = romSelect & cpuRw;

  always_comb begin
    strobes.drive  = readCycle;
    strobes.regSel = readCycle & lowMatch;
    strobes.romSel = readCycle & ~lowMatch;
  end

endmodule

// File: rtl/overlay_datapath.sv
module overlay_datapath
  import overlay_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] statusVal,
  input  logic [DATA_W-1:0] romData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  // Register value has priority over ROM data; the bus idles at zero.
  always_comb begin
    dataOut = '0;
    if (strobes.regSel)      dataOut = statusVal;
    else if (strobes.romSel) dataOut = romData;
  end

  assign dataOe = strobes.drive;

endmodule

// File: rtl/rom_overlay_decoder.sv
module rom_overlay_decoder
  import overlay_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h8000
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRw,
  input  logic              cpuPhi2,
  input  logic [DATA_W-1:0] statusVal,
  input  logic [DATA_W-1:0] romData,
  output logic              romSelect,
  output logic              romEnable,
  output logic              regEnable,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  strobe_t strobes;

  overlay_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_ctrl (
    .cpuAddr  (cpuAddr),
    .cpuRw    (cpuRw),
    .cpuPhi2  (cpuPhi2),
    .romSelect(romSelect),
    .strobes  (strobes)
  );

  overlay_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .strobes  (strobes),
    .statusVal(statusVal),
    .romData  (romData),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

  assign romEnable = strobes.romSel;
  assign regEnable = strobes.regSel;

endmodule

// File: rtl/rom_overlay_chk.sv
module rom_overlay_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuRw,
  input logic              cpuPhi2,
  input logic [DATA_W-1:0] statusVal,
  input logic [DATA_W-1:0] romData,
  input logic              romSelect,
  input logic              romEnable,
  input logic              regEnable,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);

  always_comb begin
    // R1
    window_select_chk: assert (!romSelect || (cpuAddr[ADDR_W-1] && cpuPhi2));
    // R4
    enable_mutex_chk: assert (!(romEnable && regEnable));
    // R5
    write_no_drive_chk: assert (cpuRw || !dataOe);
    // R5
    drive_needs_select_chk: assert (dataOe == (romEnable || regEnable));
    // R6
    reg_data_chk: assert (!regEnable || dataOut == statusVal);
    // R6
    rom_data_chk: assert (!romEnable || dataOut == romData);
    // R6
    idle_bus_chk: assert (dataOe || dataOut == '0);
  end

endmodule

bind rom_overlay_decoder rom_overlay_chk u_chk (
  .cpuAddr  (cpuAddr),
  .cpuRw    (cpuRw),
  .cpuPhi2  (cpuPhi2),
  .statusVal(statusVal),
  .romData  (romData),
  .romSelect(romSelect),
  .romEnable(romEnable),
  .regEnable(regEnable),
  .dataOut  (dataOut),
  .dataOe   (dataOe)
);

// File: tb/tb_rom_overlay_decoder.sv
`timescale 1ns/1ps
module tb_rom_overlay_decoder;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [15:0] cpuAddr = '0;
  logic        cpuRw = 1'b0;
  logic        cpuPhi2 = 1'b0;
  logic [7:0]  statusVal = '0;
  logic [7:0]  romData = '0;

  logic       selA, romA, regA, oeA;
  logic [7:0] outA;
  logic       selB, romB, regB, oeB;
  logic [7:0] outB;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  rom_overlay_decoder dut (
    .cpuAddr(cpuAddr), .cpuRw(cpuRw), .cpuPhi2(cpuPhi2),
    .statusVal(statusVal), .romData(romData),
    .romSelect(selA), .romEnable(romA), .regEnable(regA),
    .dataOut(outA), .dataOe(oeA)
  );

  rom_overlay_decoder #(.REG_ADDR(16'hBFFF)) dut_top (
    .cpuAddr(cpuAddr), .cpuRw(cpuRw), .cpuPhi2(cpuPhi2),
    .statusVal(statusVal), .romData(romData),
    .romSelect(selB), .romEnable(romB), .regEnable(regB),
    .dataOut(outB), .dataOe(oeB)
  );

  task automatic fail1(input string req, input string name, input int act, input int exp);
    fails++;
    $display("FAIL %s %s addr=%h rw=%0d phi2=%0d actual=%h expected=%h",
             req, name, cpuAddr, cpuRw, cpuPhi2, act, exp);
  endtask

  task automatic checkOne(input logic [15:0] regAddr, input logic sel, input logic rom,
                          input logic rg, input logic oe, input logic [7:0] dOut);
    logic eSel, eRd, eReg, eRom;
    logic [7:0] eOut;
    eSel = cpuPhi2 && (cpuAddr >= 16'h8000);
    eRd  = eSel && cpuRw;
    eReg = eRd && (cpuAddr == regAddr);
    eRom = eRd && (cpuAddr != regAddr);
    eOut = eReg ? statusVal : (eRom ? romData : 8'h00);
    vectors++;
    if (sel !== eSel) fail1("R1", "romSelect", int'(sel), int'(eSel));
    if (rg !== eReg)  fail1("R2", "regEnable", int'(rg), int'(eReg));
    if (rom !== eRom) fail1("R3", "romEnable", int'(rom), int'(eRom));
    if (rom && rg)    fail1("R4", "both_enables", 1, 0);
    if (oe !== eRd)   fail1("R5", "dataOe", int'(oe), int'(eRd));
    if (dOut !== eOut) fail1("R6", "dataOut", int'(dOut), int'(eOut));
  endtask

  initial begin
    // Idle inputs: nothing selected, bus not driven (R1, R5, R6).
    #1;
    checkOne(16'h8000, selA, romA, regA, oeA, outA);
    checkOne(16'hBFFF, selB, romB, regB, oeB, outB);
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int a = 0; a < 65536; a++) begin
          cpuAddr   = a[15:0];
          cpuPhi2   = p[0];
          cpuRw     = w[0];
          statusVal = {a[3:0], a[15:12]} ^ {7'h0, p[0]};
          romData   = a[15:8] ^ a[7:0] ^ 8'hA5;
          // R7: sampled 1 ns after the inputs change, no clock edge involved.
          #1;
          checkOne(16'h8000, selA, romA, regA, oeA, outA);
          checkOne(16'hBFFF, selB, romB, regB, oeB, outB);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule